// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level and Character Timeout

This block buffers received characters between a serial deserializer and a host for a 16550-style UART. The deserializer offers bytes with a one-cycle push strobe (optionally flagged as a break character); the host removes the oldest byte with a one-cycle read strobe and sees that byte on the data output during the same cycle. The block reports how many bytes it holds, and whether that fill has reached a programmable trigger level. It also keeps the data-ready, break and overrun flags.

A byte written to the FIFO control port sets the operating mode. Bit 0 enables queued mode, bits 7:6 choose the trigger level, bit 1 flushes the receive queue and bit 2 requests a flush of the transmit queue, which is signalled as a one-cycle pulse. A character-timeout detector counts 16x baud ticks. It raises a timeout-pending flag when bytes sit in the queue for four character times with no push and no host read. The character time follows the current line settings.

When queued mode is off, the block behaves as a single holding register with no timeout.

Top module: `uart_rx_queue`

## Requirements
- R1: In queued mode the block holds up to 16 bytes and returns them in push order; `fill` equals the number of bytes held.
- R2: In queued mode `trig_hit` is high exactly when `fill` is at least the level selected by control bits 7:6: code 0 gives 1, code 1 gives 4, code 2 gives 8, code 3 gives 14.
- R3: A control write keeps only bits 7, 6, 3 and 0 (mask 0xC9) on `fcr_q`. Bit 1 set empties the receive queue. Bit 2 set drives `tx_clr` high during the write cycle.
- R4: A control write whose bit 0 differs from `fcr_q[0]` empties the receive queue and pulses `tx_clr`, whatever bits 1 and 2 hold.
- R5: A read of an empty queue returns 0x00. An accepted push sets `data_rdy`. A read that leaves the queue empty clears `data_rdy`.
- R6: A push into a full queue is discarded and sets `ovr_flag`; a pulse on `lsr_rd` clears `ovr_flag`.
- R7: In queued mode, exactly 64 x (frame bits) `baud_tick` pulses after the last push, or after the last read that left data behind, `tmo_pend` goes high if data remain. Frame bits are 1 start + (`line_cfg[1:0]`+5) data + `line_cfg[3]` parity + 2 stop if `line_cfg[2]` is set, else 1 stop.
- R8: A host read, or a flush of the receive queue, clears `tmo_pend`.
- R9: With queued mode off, the queue holds at most one byte, a second push is an overrun, `trig_hit` follows `data_rdy`, and `tmo_pend` never rises.
- R10: A push with `push_brk` high stores 0x00 and sets `brk_flag`; `brk_flag` clears when a read empties the queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | FIFO control write strobe |
| cfg_wdata | input | 8 | FIFO control write value |
| line_cfg | input | 4 | Line settings: [1:0] data length code, [2] two stop bits, [3] parity on |
| baud_tick | input | 1 | One pulse per 16x baud sample period |
| push | input | 1 | Received byte strobe |
| push_data | input | 8 | Received byte |
| push_brk | input | 1 | Received character is a break |
| pop | input | 1 | Host read strobe |
| pop_data | output | 8 | Oldest byte, 0x00 when empty |
| lsr_rd | input | 1 | Line status read, clears overrun |
| fill | output | 5 | Bytes held |
| trig_hit | output | 1 | Trigger level reached |
| tmo_pend | output | 1 | Character timeout pending |
| data_rdy | output | 1 | Data ready |
| brk_flag | output | 1 | Break received |
| ovr_flag | output | 1 | Overrun occurred |
| fcr_q | output | 8 | Stored control bits |
| tx_clr | output | 1 | Transmit queue flush request |

## Verification
A corrupted pointer or count in the queue shows up at the first read after it: a wrong byte appears on `pop_data`, or `fill` disagrees with the number of pushes minus reads. A timer that restarts at the wrong moment, or uses the wrong limit, shows as `tmo_pend` rising one or more ticks away from 64 x frame bits. The bench therefore probes that flag one tick before the limit and again at the limit, for several line settings. Flag state is observed in the cycle after the strobe that changes it, so a stale flag is visible one clock after the event.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Bits per serial character for a given line setting
  function automatic logic [3:0] frame_bits(input logic [3:0] lc);
    logic [3:0] n;
    n = 4'd1 + ({2'b00, lc[1:0]} + 4'd5) + {3'b000, lc[3]} + (lc[2] ? 4'd2 : 4'd1);
    return n;
  endfunction

  // Trigger level in bytes for control bits 7:6
  function automatic logic [4:0] trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (wr_en) wp <= bump(wp);
      if (rd_en) rp <= bump(rp);
      case ({wr_en, rd_en})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign rd_data = (count == '0) ? '0 : mem[rp];
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          stop,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt;
  logic          armed;

  assign expire = armed & tick & (cnt == limit - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; cnt <= '0;
    end else if (stop) begin
      armed <= 1'b0; cnt <= '0;
    end else if (restart) begin
      armed <= 1'b1; cnt <= '0;
    end else if (expire) begin
      armed <= 1'b0;
    end else if (armed && tick) begin
      cnt <= cnt + TW'(1);
    end
  end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int WIDTH         = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int TMO_CHARS     = 4,
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int TICK_MULT = TICKS_PER_BIT * TMO_CHARS,
  localparam int TW        = $clog2(12 * TICK_MULT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  input  logic [3:0]       line_cfg,
  input  logic             baud_tick,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             push_brk,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  input  logic             lsr_rd,
  output logic [CW-1:0]    fill,
  output logic             trig_hit,
  output logic             tmo_pend,
  output logic             data_rdy,
  output logic             brk_flag,
  output logic             ovr_flag,
  output logic [7:0]       fcr_q,
  output logic             tx_clr
);
  // Named internal events
  logic          fifo_en, en_toggle, rx_clr, push_ok, pop_ok, leaves_empty;
  logic          tmo_restart, tmo_stop, tmo_expire;
  logic [CW-1:0] cap;
  logic [TW-1:0] tmo_limit;

  assign fifo_en      = fcr_q[0];
  assign en_toggle    = cfg_we & (cfg_wdata[0] ^ fcr_q[0]);
  assign rx_clr       = cfg_we & (cfg_wdata[1] | en_toggle);
  assign tx_clr       = cfg_we & (cfg_wdata[2] | en_toggle);
  assign cap          = fifo_en ? CW'(DEPTH) : CW'(1);
  assign push_ok      = push & ~rx_clr & (fill < cap);
  assign pop_ok       = pop & ~rx_clr & (fill != '0);
  assign leaves_empty = pop_ok & ~push_ok & (fill == CW'(1));

  assign tmo_limit   = TW'(32'(frame_bits(line_cfg)) * TICK_MULT);
  assign tmo_restart = fifo_en & (push_ok | (pop_ok & (fill > CW'(1))));
  assign tmo_stop    = rx_clr | leaves_empty | ~fifo_en;

  assign trig_hit = fifo_en ? (fill >= CW'(trig_level(fcr_q[7:6]))) : data_rdy;

  rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (rx_clr),
    .wr_en   (push_ok),
    .wr_data (push_brk ? '0 : push_data),
    .rd_en   (pop_ok),
    .rd_data (pop_data),
    .count   (fill)
  );

  rxq_timeout #(.TW(TW)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmo_restart),
    .stop    (tmo_stop),
    .tick    (baud_tick),
    .limit   (tmo_limit),
    .expire  (tmo_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcr_q    <= 8'h00;
      data_rdy <= 1'b0;
      brk_flag <= 1'b0;
      ovr_flag <= 1'b0;
      tmo_pend <= 1'b0;
    end else begin
      if (cfg_we) fcr_q <= cfg_wdata & 8'hC9;

      if (rx_clr)            data_rdy <= 1'b0;
      else if (push_ok)      data_rdy <= 1'b1;
      else if (leaves_empty) data_rdy <= 1'b0;

      if (rx_clr)                   brk_flag <= 1'b0;
      else if (push_ok && push_brk) brk_flag <= 1'b1;
      else if (leaves_empty)        brk_flag <= 1'b0;

      if (push && !rx_clr && !push_ok) ovr_flag <= 1'b1;
      else if (lsr_rd)                 ovr_flag <= 1'b0;

      if (rx_clr || pop)                   tmo_pend <= 1'b0;
      else if (tmo_expire && fill != '0)   tmo_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          pop,
  input logic          cfg_we,
  input logic [7:0]    cfg_wdata,
  input logic [7:0]    fcr_q,
  input logic [CW-1:0] fill,
  input logic          data_rdy,
  input logic          tmo_pend,
  input logic          ovr_flag,
  input logic          rx_clr
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH)); // R1
  AST_TOGGLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_wdata[0] != fcr_q[0])) |=> (fill == '0)); // R4
  AST_EMPTY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |-> !data_rdy); // R5
  AST_OVERRUN_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !rx_clr && fill == CW'(DEPTH)) |=> ovr_flag); // R6
  AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pend |-> (fill != '0)); // R7
  AST_READ_CLEARS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !tmo_pend); // R8
  AST_SINGLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fcr_q[0] |-> (fill <= CW'(1))); // R9
endmodule

bind uart_rx_queue rxq_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .push      (push),
  .pop       (pop),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .fcr_q     (fcr_q),
  .fill      (fill),
  .data_rdy  (data_rdy),
  .tmo_pend  (tmo_pend),
  .ovr_flag  (ovr_flag),
  .rx_clr    (rx_clr)
);

// File: tb/uart_rx_queue_tb.sv
module uart_rx_queue_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [3:0] line_cfg = 4'h0;
  logic       baud_tick = 1'b0;
  logic       push = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic       push_brk = 1'b0;
  logic       pop = 1'b0;
  logic       lsr_rd = 1'b0;
  logic [7:0] pop_data;
  logic [4:0] fill;
  logic       trig_hit, tmo_pend, data_rdy, brk_flag, ovr_flag, tx_clr;
  logic [7:0] fcr_q;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic       seen_tx_clr;
  logic [7:0] got;

  always #10 clk = ~clk;

  uart_rx_queue u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .line_cfg(line_cfg), .baud_tick(baud_tick), .push(push),
    .push_data(push_data), .push_brk(push_brk), .pop(pop),
    .pop_data(pop_data), .lsr_rd(lsr_rd), .fill(fill), .trig_hit(trig_hit),
    .tmo_pend(tmo_pend), .data_rdy(data_rdy), .brk_flag(brk_flag),
    .ovr_flag(ovr_flag), .fcr_q(fcr_q), .tx_clr(tx_clr)
  );

  // {line_cfg, expected timeout ticks = 64 x frame bits}
  localparam logic [19:0] TMO_VEC [5] = '{
    {4'h0, 16'd448},   // 1+5+1
    {4'h3, 16'd640},   // 1+8+1
    {4'h7, 16'd704},   // 1+8+2
    {4'h9, 16'd576},   // 1+6+1+1
    {4'hF, 16'd768}    // 1+8+1+2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_push(input logic [7:0] d, input logic b);
    @(negedge clk); push = 1'b1; push_data = d; push_brk = b;
    @(negedge clk); push = 1'b0; push_brk = 1'b0;
  endtask

  task automatic do_pop(output logic [7:0] d);
    @(negedge clk); pop = 1'b1; #1 d = pop_data;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic fcr_write(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v; #1 seen_tx_clr = tx_clr;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); baud_tick = 1'b1;
    end
    @(negedge clk); baud_tick = 1'b0;
  endtask

  function automatic int level_of(input int code);
    if (code == 0) return 1;
    if (code == 1) return 4;
    if (code == 2) return 8;
    return 14;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R5 reset fill", fill, 0);
    chk("R5 reset data_rdy", data_rdy, 0);
    chk("R3 reset fcr_q", fcr_q, 8'h00);
    chk("R8 reset tmo_pend", tmo_pend, 0);

    // Holding-register mode (queued mode off)
    do_push(8'hA5, 1'b0);
    chk("R9 ready after push", data_rdy, 1);
    chk("R9 trig follows ready", trig_hit, 1);
    do_push(8'h3C, 1'b0);
    chk("R9 second push overrun", ovr_flag, 1);
    chk("R9 capacity one", fill, 1);
    @(negedge clk); lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
    chk("R6 lsr read clears overrun", ovr_flag, 0);
    ticks(800);
    chk("R9 no timeout when off", tmo_pend, 0);
    do_pop(got);
    chk("R9 holding byte", got, 8'hA5);
    chk("R5 ready cleared on empty", data_rdy, 0);
    do_pop(got);
    chk("R5 empty read is zero", got, 8'h00);

    // Enable with flush bits; stored mask
    fcr_write(8'h07);
    chk("R3 tx_clr on bit 2", seen_tx_clr, 1);
    chk("R3 stored mask", fcr_q, 8'h01);
    fcr_write(8'hFF);
    chk("R3 stored mask all ones", fcr_q, 8'hC9);
    fcr_write(8'h01);
    chk("R3 no tx_clr without bit 2", seen_tx_clr, 0);

    // Fill to 16, overrun, ordered drain
    for (int i = 0; i < 16; i++) do_push(8'(i * 7 + 1), 1'b0);
    chk("R1 fill full", fill, 16);
    do_push(8'hEE, 1'b0);
    chk("R6 overrun when full", ovr_flag, 1);
    chk("R6 full push dropped", fill, 16);
    for (int i = 0; i < 16; i++) begin
      do_pop(got);
      chk("R1 order", got, 8'(i * 7 + 1));
    end
    chk("R1 drained", fill, 0);
    chk("R5 ready clear after drain", data_rdy, 0);
    do_pop(got);
    chk("R5 empty read zero queued", got, 8'h00);
    @(negedge clk); lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;

    // Trigger levels
    for (int code = 0; code < 4; code++) begin
      int lv;
      lv = level_of(code);
      fcr_write({2'(code), 6'b000001});
      for (int j = 0; j < lv - 1; j++) do_push(8'(j), 1'b0);
      chk("R2 below trigger", trig_hit, 0);
      do_push(8'h55, 1'b0);
      chk("R2 at trigger", trig_hit, 1);
      fcr_write({2'(code), 6'b000011});
      chk("R3 bit 1 flushes", fill, 0);
    end
    fcr_write(8'h01);

    // Timeout limit for several line settings
    for (int i = 0; i < 5; i++) begin
      int lim;
      line_cfg = TMO_VEC[i][19:16];
      lim = int'(TMO_VEC[i][15:0]);
      do_push(8'(8'h90 + i), 1'b0);
      ticks(lim - 1);
      chk("R7 not yet at limit-1", tmo_pend, 0);
      ticks(1);
      chk("R7 pending at limit", tmo_pend, 1);
      do_pop(got);
      chk("R8 read clears timeout", tmo_pend, 0);
      chk("R7 byte kept", got, 8'(8'h90 + i));
    end

    // Restart by push and by a read leaving data
    line_cfg = 4'h0;
    do_push(8'h11, 1'b0);
    ticks(300);
    do_push(8'h22, 1'b0);
    ticks(447);
    chk("R7 push restarts timer", tmo_pend, 0);
    ticks(1);
    chk("R7 pending after restart", tmo_pend, 1);
    do_pop(got);
    chk("R8 read clears pending", tmo_pend, 0);
    ticks(447);
    chk("R7 read restarts timer", tmo_pend, 0);
    ticks(1);
    chk("R7 pending after read restart", tmo_pend, 1);
    do_pop(got);
    ticks(800);
    chk("R7 no timeout when empty", tmo_pend, 0);

    // Flush clears pending
    do_push(8'h33, 1'b0);
    ticks(448);
    chk("R7 pending before flush", tmo_pend, 1);
    fcr_write(8'h03);
    chk("R8 flush clears pending", tmo_pend, 0);

    // Enable toggle forces flushes
    do_push(8'h44, 1'b0);
    do_push(8'h45, 1'b0);
    fcr_write(8'hC0);
    chk("R4 disable flushes rx", fill, 0);
    chk("R4 disable pulses tx_clr", seen_tx_clr, 1);
    chk("R4 stored after disable", fcr_q, 8'hC0);
    do_push(8'h46, 1'b0);
    fcr_write(8'hC1);
    chk("R4 enable flushes rx", fill, 0);
    chk("R4 enable pulses tx_clr", seen_tx_clr, 1);

    // Break characters
    do_push(8'h7E, 1'b1);
    do_push(8'h55, 1'b0);
    chk("R10 break flag set", brk_flag, 1);
    do_pop(got);
    chk("R10 break byte is zero", got, 8'h00);
    chk("R10 break held while data left", brk_flag, 1);
    do_pop(got);
    chk("R10 next byte", got, 8'h55);
    chk("R10 break cleared on empty", brk_flag, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule